// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block caches virtual-to-physical page translations for a processor's load/store and fetch paths. Every entry holds a virtual page number, the address-space identifier of the process that owns it, a physical frame number, a writable bit and a wired bit. A lookup searches all entries at once and needs both the page number and the identifier to match. Entries from different processes can therefore live side by side, and a context switch needs no flush.

After a miss, a separate page-table walker installs the translation it fetched through the fill port. A fill whose identifier and page number are already present rewrites that entry. Any other fill takes a victim chosen by a round-robin pointer that steps over wired entries, so wired translations are never replaced. Two flush commands remove translations: one clears every non-wired entry, and the other clears only the non-wired entries of a single address space.

`ENTRIES` must be a power of two between 64 and 1024.

Top module: `asid_tlb`

## Requirements
- R1: A lookup hits only when a valid entry matches both `lk_asid_i` and `lk_vpn_i`. The result appears on the `res_*` outputs one clock after `lk_valid_i` is sampled, with `res_valid_o` high for that one cycle and `res_pfn_o` set to the entry's frame number.
- R2: A lookup that matches no valid entry returns `res_hit_o`=0, `res_pfn_o`=0 and `res_fault_o`=0.
- R3: `res_fault_o` is 1 only for a hit with `lk_write_i`=1 on an entry that was filled with `fill_writable_i`=0. A read of such an entry, or a write to an entry filled with `fill_writable_i`=1, gives `res_fault_o`=0.
- R4: After a fill, later lookups with the same identifier and page number hit and return the filled frame number.
- R5: When a lookup and a fill happen in the same cycle, the lookup sees the table as it was before the fill.
- R6: A fill whose identifier and page number match a valid entry rewrites that entry in place and creates no second entry, so later lookups return the new frame number.
- R7: Victims are chosen round-robin. The pointer starts at entry 0 after reset and moves to the slot after each victim. Wired slots are stepped over, so the first fill after all ENTRIES slots are used evicts the oldest non-wired entry.
- R8: A fill that is not a rewrite while every entry is wired changes nothing and pulses `fill_err_o` high for one cycle, one clock after the fill. Every other fill leaves `fill_err_o` at 0.
- R9: `flush_all_i` invalidates every non-wired entry in one cycle. Wired entries keep hitting.
- R10: `flush_asid_i` invalidates only the non-wired entries whose identifier equals `flush_asid_val_i`. Entries of other address spaces, and wired entries, keep hitting.
- R11: During and after reset no entry is valid and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_asid_i | input | ASID_W | Address space of the lookup |
| lk_vpn_i | input | VPN_W | Virtual page number of the lookup |
| lk_write_i | input | 1 | Lookup is for a write access |
| res_valid_o | output | 1 | Lookup result is valid |
| res_hit_o | output | 1 | Translation found |
| res_pfn_o | output | PFN_W | Frame number (0 on a miss) |
| res_fault_o | output | 1 | Write to a read-only page |
| fill_valid_i | input | 1 | Install a translation |
| fill_asid_i | input | ASID_W | Address space of the fill |
| fill_vpn_i | input | VPN_W | Page number of the fill |
| fill_pfn_i | input | PFN_W | Frame number of the fill |
| fill_writable_i | input | 1 | Page allows writes |
| fill_wired_i | input | 1 | Entry is excluded from replacement |
| fill_err_o | output | 1 | Fill dropped because all entries are wired |
| flush_all_i | input | 1 | Invalidate all non-wired entries |
| flush_asid_i | input | 1 | Invalidate non-wired entries of one address space |
| flush_asid_val_i | input | ASID_W | Address space to flush |

## Verification
The assertions rely on the table never holding two valid entries with the same identifier and page number. This holds only because every fill goes through the rewrite check, so the bench only installs translations through the fill port and never forces state. The assertions also treat a wired entry as permanent. The stimulus therefore never unwires an entry, and it uses reset rather than a flush to clear the table between the replacement and all-wired scenarios. Inputs change only on the falling clock edge, one operation per cycle, except in the deliberate same-cycle lookup-and-fill case.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned DEF_ENTRIES = 64;
  localparam int unsigned DEF_ASID_W  = 8;
  localparam int unsigned DEF_VPN_W   = 20;
  localparam int unsigned DEF_PFN_W   = 16;

  typedef struct packed {
    logic valid;
    logic wired;
    logic writable;
  } tlb_flags_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned N      = 64,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned VPN_W  = 20
) (
  input  logic [N-1:0]      valid_i,
  input  logic [ASID_W-1:0] asid_i [N],
  input  logic [VPN_W-1:0]  vpn_i  [N],
  input  logic [ASID_W-1:0] q_asid_i,
  input  logic [VPN_W-1:0]  q_vpn_i,
  output logic [N-1:0]      match_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match_o[i] = valid_i[i] && (asid_i[i] == q_asid_i) && (vpn_i[i] == q_vpn_i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned N     = 64,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     wired_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic [IDX_W-1:0] victim_o,
  output logic             found_o
);
  // First non-wired slot at or after ptr, wrapping (N is a power of two)
  always_comb begin
    logic [IDX_W-1:0] idx;
    found_o  = 1'b0;
    victim_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = ptr_i + IDX_W'(k);
      if (!wired_i[idx]) begin
        found_o  = 1'b1;
        victim_o = idx;
      end
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int unsigned ENTRIES = tlb_pkg::DEF_ENTRIES,
  parameter int unsigned ASID_W  = tlb_pkg::DEF_ASID_W,
  parameter int unsigned VPN_W   = tlb_pkg::DEF_VPN_W,
  parameter int unsigned PFN_W   = tlb_pkg::DEF_PFN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic              lk_write_i,
  output logic              res_valid_o,
  output logic              res_hit_o,
  output logic [PFN_W-1:0]  res_pfn_o,
  output logic              res_fault_o,
  input  logic              fill_valid_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic              fill_writable_i,
  input  logic              fill_wired_i,
  output logic              fill_err_o,
  input  logic              flush_all_i,
  input  logic              flush_asid_i,
  input  logic [ASID_W-1:0] flush_asid_val_i
);
  import tlb_pkg::*;

  localparam int unsigned IDX_W = $clog2(ENTRIES);

  if (ENTRIES < 64 || ENTRIES > 1024 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
    $error("asid_tlb: ENTRIES must be a power of two in 64..1024");
  end

  tlb_flags_t        flags_q [ENTRIES];
  logic [ASID_W-1:0] asid_q  [ENTRIES];
  logic [VPN_W-1:0]  vpn_q   [ENTRIES];
  logic [PFN_W-1:0]  pfn_q   [ENTRIES];
  logic [IDX_W-1:0]  ptr_q;

  logic [ENTRIES-1:0] valid_vec, wired_vec, lk_match, fill_match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_vec
    assign valid_vec[i] = flags_q[i].valid;
    assign wired_vec[i] = flags_q[i].wired;
  end

  tlb_match #(.N(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_lk_match (
    .valid_i(valid_vec), .asid_i(asid_q), .vpn_i(vpn_q),
    .q_asid_i(lk_asid_i), .q_vpn_i(lk_vpn_i), .match_o(lk_match)
  );

  tlb_match #(.N(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_fill_match (
    .valid_i(valid_vec), .asid_i(asid_q), .vpn_i(vpn_q),
    .q_asid_i(fill_asid_i), .q_vpn_i(fill_vpn_i), .match_o(fill_match)
  );

  logic [IDX_W-1:0] vic_idx;
  logic             vic_found;

  tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .wired_i(wired_vec), .ptr_i(ptr_q), .victim_o(vic_idx), .found_o(vic_found)
  );

  // Match vectors are one-hot at most, so an AND-OR mux suffices
  logic [PFN_W-1:0] lk_pfn;
  logic             lk_rw;
  logic [IDX_W-1:0] dup_idx;
  always_comb begin
    lk_pfn  = '0;
    lk_rw   = 1'b0;
    dup_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_pfn = lk_pfn | pfn_q[i];
        lk_rw  = lk_rw | flags_q[i].writable;
      end
      if (fill_match[i]) dup_idx = dup_idx | IDX_W'(i);
    end
  end

  logic             lk_hit, dup_hit, fill_do, fill_new;
  logic [IDX_W-1:0] fill_idx;
  assign lk_hit   = |lk_match;
  assign dup_hit  = |fill_match;
  assign fill_new = fill_valid_i && !dup_hit;
  assign fill_do  = fill_valid_i && (dup_hit || vic_found);
  assign fill_idx = dup_hit ? dup_idx : vic_idx;

  // Flush applies first; a fill in the same cycle survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) begin
        flags_q[i] <= '0;
        asid_q[i]  <= '0;
        vpn_q[i]   <= '0;
        pfn_q[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (!flags_q[i].wired &&
            (flush_all_i || (flush_asid_i && asid_q[i] == flush_asid_val_i)))
          flags_q[i].valid <= 1'b0;
        if (fill_do && fill_idx == IDX_W'(i)) begin
          flags_q[i] <= '{valid: 1'b1, wired: fill_wired_i, writable: fill_writable_i};
          asid_q[i]  <= fill_asid_i;
          vpn_q[i]   <= fill_vpn_i;
          pfn_q[i]   <= fill_pfn_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q       <= '0;
      fill_err_o  <= 1'b0;
      res_valid_o <= 1'b0;
      res_hit_o   <= 1'b0;
      res_pfn_o   <= '0;
      res_fault_o <= 1'b0;
    end else begin
      if (fill_new && vic_found) ptr_q <= vic_idx + 1'b1;
      fill_err_o  <= fill_new && !vic_found;
      res_valid_o <= lk_valid_i;
      res_hit_o   <= lk_valid_i && lk_hit;
      res_pfn_o   <= (lk_valid_i && lk_hit) ? lk_pfn : '0;
      res_fault_o <= lk_valid_i && lk_hit && lk_write_i && !lk_rw;
    end
  end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int unsigned N = 64
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         lk_valid_i,
  input logic         fill_valid_i,
  input logic         res_valid_o,
  input logic         res_hit_o,
  input logic         res_fault_o,
  input logic         res_pfn_nz,
  input logic         fill_err_o,
  input logic [N-1:0] lk_match,
  input logic [N-1:0] fill_match,
  input logic [N-1:0] valid_vec,
  input logic [N-1:0] wired_vec
);
  // R6: rewrite-in-place keeps translations unique
  a_r6_unique_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match));
  a_r6_unique_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fill_match));
  // R1: one-cycle result timing
  a_r1_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> res_valid_o);
  a_r1_hit_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_hit_o |-> res_valid_o);
  // R3: fault only on a hit
  a_r3_fault_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_fault_o |-> res_hit_o);
  // R2: miss returns zero frame
  a_r2_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_hit_o) |-> !res_pfn_nz);
  // R8: error only after a fill with the table fully wired
  a_r8_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_err_o |-> ($past(fill_valid_i) && (&$past(wired_vec))));
  // R9 / R10: a valid wired entry never loses validity
  a_r9_wired_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(valid_vec & wired_vec)) & ~valid_vec) == '0);
endmodule

bind asid_tlb tlb_checker #(.N(ENTRIES)) u_tlb_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_valid_i(lk_valid_i), .fill_valid_i(fill_valid_i),
  .res_valid_o(res_valid_o), .res_hit_o(res_hit_o), .res_fault_o(res_fault_o),
  .res_pfn_nz(|res_pfn_o), .fill_err_o(fill_err_o), .lk_match(lk_match),
  .fill_match(fill_match), .valid_vec(valid_vec), .wired_vec(wired_vec)
);

// File: tb/asid_tlb_test.sv
module asid_tlb_test;
  localparam int unsigned N = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid_i = 0, lk_write_i = 0;
  logic [7:0]  lk_asid_i = 0;
  logic [19:0] lk_vpn_i = 0;
  logic        res_valid_o, res_hit_o, res_fault_o, fill_err_o;
  logic [15:0] res_pfn_o;
  logic        fill_valid_i = 0, fill_writable_i = 0, fill_wired_i = 0;
  logic [7:0]  fill_asid_i = 0;
  logic [19:0] fill_vpn_i = 0;
  logic [15:0] fill_pfn_i = 0;
  logic        flush_all_i = 0, flush_asid_i = 0;
  logic [7:0]  flush_asid_val_i = 0;

  always #10 clk_i = ~clk_i;

  asid_tlb #(.ENTRIES(N)) uut (.*);

  typedef struct {
    string       tag;
    logic        hit;
    logic [15:0] pfn;
    logic        fault;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: compare each result against the oldest expectation
  always @(negedge clk_i) begin
    if (rst_ni && res_valid_o) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R1: actual unexpected result expected none");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " hit"},   32'(res_hit_o),   32'(e.hit));
        check({e.tag, " pfn"},   32'(res_pfn_o),   32'(e.pfn));
        check({e.tag, " fault"}, 32'(res_fault_o), 32'(e.fault));
      end
    end
  end

  // All tasks are entered at a falling edge and return at the next one
  task automatic drive_lk(logic [7:0] a, logic [19:0] v, logic w,
                          string tag, logic h, logic [15:0] p, logic f);
    exp_t e;
    lk_valid_i = 1; lk_asid_i = a; lk_vpn_i = v; lk_write_i = w;
    e.tag = tag; e.hit = h; e.pfn = p; e.fault = f;
    exp_q.push_back(e);
  endtask

  task automatic drive_fill(logic [7:0] a, logic [19:0] v, logic [15:0] p, logic rw, logic wd);
    fill_valid_i = 1; fill_asid_i = a; fill_vpn_i = v; fill_pfn_i = p;
    fill_writable_i = rw; fill_wired_i = wd;
  endtask

  task automatic idle_step();
    @(negedge clk_i);
    lk_valid_i = 0; fill_valid_i = 0; flush_all_i = 0; flush_asid_i = 0;
  endtask

  task automatic lookup(logic [7:0] a, logic [19:0] v, logic w,
                        string tag, logic h, logic [15:0] p, logic f);
    drive_lk(a, v, w, tag, h, p, f);
    idle_step();
  endtask

  task automatic fill(logic [7:0] a, logic [19:0] v, logic [15:0] p, logic rw, logic wd);
    drive_fill(a, v, p, rw, wd);
    idle_step();
  endtask

  task automatic drain();
    repeat (2) @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    // R11: outputs while in reset
    check("R11 res_valid", 32'(res_valid_o), 0);
    check("R11 res_hit", 32'(res_hit_o), 0);
    check("R11 res_pfn", 32'(res_pfn_o), 0);
    check("R11 fill_err", 32'(fill_err_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    lookup(8'd1, 20'd5, 0, "R11 empty after reset", 0, 0, 0);

    // R4 / R1 / R2
    fill(8'd1, 20'd5, 16'h11, 1, 0);
    check("R8 normal fill no error", 32'(fill_err_o), 0);
    lookup(8'd1, 20'd5, 0, "R4 filled entry hits", 1, 16'h11, 0);
    lookup(8'd2, 20'd5, 0, "R1 other asid misses", 0, 0, 0);
    lookup(8'd1, 20'd6, 0, "R2 other vpn misses", 0, 0, 0);
    fill(8'd2, 20'd5, 16'h22, 1, 0);
    lookup(8'd2, 20'd5, 0, "R1 asid2 entry", 1, 16'h22, 0);
    lookup(8'd1, 20'd5, 0, "R1 asid1 entry kept", 1, 16'h11, 0);

    // R6: rewrite in place
    fill(8'd1, 20'd5, 16'h44, 1, 0);
    lookup(8'd1, 20'd5, 0, "R6 rewritten frame", 1, 16'h44, 0);

    // R3: protection
    fill(8'd1, 20'd20, 16'h33, 0, 0);
    fill(8'd1, 20'd21, 16'h34, 1, 0);
    lookup(8'd1, 20'd20, 1, "R3 write to read-only faults", 1, 16'h33, 1);
    lookup(8'd1, 20'd20, 0, "R3 read of read-only ok", 1, 16'h33, 0);
    lookup(8'd1, 20'd21, 1, "R3 write to writable ok", 1, 16'h34, 0);
    lookup(8'd1, 20'd30, 1, "R3 write miss no fault", 0, 0, 0);

    // R5: lookup and fill in the same cycle
    drive_lk(8'd3, 20'd40, 0, "R5 same-cycle lookup sees old table", 0, 0, 0);
    drive_fill(8'd3, 20'd40, 16'h55, 1, 0);
    idle_step();
    lookup(8'd3, 20'd40, 0, "R5 fill visible next cycle", 1, 16'h55, 0);

    // R10: per-asid flush
    fill(8'd2, 20'd9, 16'h99, 1, 1);
    flush_asid_i = 1; flush_asid_val_i = 8'd2;
    idle_step();
    lookup(8'd2, 20'd5, 0, "R10 flushed asid entry", 0, 0, 0);
    lookup(8'd2, 20'd9, 0, "R10 wired entry kept", 1, 16'h99, 0);
    lookup(8'd1, 20'd5, 0, "R10 other asid kept", 1, 16'h44, 0);

    // R9: flush all
    flush_all_i = 1;
    idle_step();
    lookup(8'd1, 20'd5, 0, "R9 flushed entry", 0, 0, 0);
    lookup(8'd3, 20'd40, 0, "R9 flushed entry asid3", 0, 0, 0);
    lookup(8'd2, 20'd9, 0, "R9 wired entry kept", 1, 16'h99, 0);
    drain();

    // R7: round-robin replacement skipping wired
    do_reset();
    for (int i = 0; i < N; i++) fill(8'd1, 20'(100 + i), 16'(i + 1), 1, (i < 2));
    fill(8'd1, 20'd500, 16'h500, 1, 0);
    lookup(8'd1, 20'd102, 0, "R7 oldest non-wired evicted", 0, 0, 0);
    lookup(8'd1, 20'd100, 0, "R7 wired slot 0 kept", 1, 16'd1, 0);
    lookup(8'd1, 20'd101, 0, "R7 wired slot 1 kept", 1, 16'd2, 0);
    lookup(8'd1, 20'd103, 0, "R7 next entry kept", 1, 16'd4, 0);
    lookup(8'd1, 20'd500, 0, "R7 new entry hits", 1, 16'h500, 0);
    fill(8'd1, 20'd501, 16'h501, 1, 0);
    lookup(8'd1, 20'd103, 0, "R7 pointer advanced", 0, 0, 0);
    lookup(8'd1, 20'd104, 0, "R7 later entry kept", 1, 16'd5, 0);
    drain();

    // R8: all entries wired
    do_reset();
    for (int i = 0; i < N; i++) fill(8'd4, 20'(200 + i), 16'(i + 7), 1, 1);
    check("R8 last wired fill no error", 32'(fill_err_o), 0);
    fill(8'd4, 20'd900, 16'h900, 1, 0);
    check("R8 full-wired fill error", 32'(fill_err_o), 1);
    @(negedge clk_i);
    check("R8 error is one pulse", 32'(fill_err_o), 0);
    lookup(8'd4, 20'd900, 0, "R8 dropped fill misses", 0, 0, 0);
    lookup(8'd4, 20'd200, 0, "R8 table intact", 1, 16'd7, 0);
    fill(8'd4, 20'd201, 16'hABC, 1, 1);
    check("R8 rewrite when full no error", 32'(fill_err_o), 0);
    lookup(8'd4, 20'd201, 0, "R6 rewrite of wired entry", 1, 16'hABC, 0);
    drain();

    check("R1 all results returned", 32'(exp_q.size()), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule